// File: doc/BRIEF.md
# Sign-Magnitude Adder-Subtractor

This block adds or subtracts two signed integers held in sign-magnitude form and returns the result in the same form. It is purely combinational. Each operand is one word: the top bit is the sign, where 1 means negative, and the lower bits are an unsigned magnitude. With the default width of 8 bits, every value from -127 to +127 can be written. Zero has two codes, +0 and -0.

To subtract, the block flips the sign of the second operand and then takes the add path unchanged. When the two effective signs are equal, the magnitudes are added and the result takes the common sign. A carry out of the top magnitude bit is reported as overflow. When the signs differ, the second magnitude is complemented and the two are added. A carry out of the top magnitude bit is then fed back into the lowest bit. If there was no carry, the sum is complemented back to recover the true magnitude.

A zero result always leaves the block as +0, and a -0 operand behaves exactly as +0. The magnitude alone does not give the order of two values. A consumer that needs the sign must read the sign bit.

Top module: `sm_addsub`

## Requirements
- R1: With `op_i` = 1 the block returns the same result, overflow and zero values as with `op_i` = 0 and the sign bit (bit W-1) of `b_i` inverted. A subtract is therefore A - B and an add is A + B.
- R2: When the effective signs are equal and the magnitude sum fits in W-1 bits, the result magnitude is the sum of the input magnitudes and the result sign is the common sign.
- R3: When the effective signs are equal and the magnitude sum exceeds 2^(W-1)-1, `ovf_o` is 1 and the result magnitude is the low W-1 bits of that sum.
- R4: When the effective signs differ, the result magnitude is the absolute difference of the input magnitudes. The result sign is the sign of the operand with the larger magnitude.
- R5: A result whose magnitude is 0 is always output with sign bit 0. This includes a wrapped overflow result.
- R6: `zero_o` is 1 exactly when the result magnitude is 0.
- R7: An operand with sign 1 and magnitude 0 gives the same outputs as +0 in every operation.
- R8: `ovf_o` is 0 whenever the effective signs of the two operands differ.
- R9: The extremes of the range (+/-(2^(W-1)-1), i.e. +/-127 at 8 bits) are handled. Examples: 127 + (-127) = +0, and 127 - (-127) overflows with magnitude 126.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | W | Operand A, sign bit W-1 (1 = negative), magnitude bits W-2:0 |
| b_i | input | W | Operand B, same encoding |
| op_i | input | 1 | 0 = add (A + B), 1 = subtract (A - B) |
| res_o | output | W | Sign-magnitude result |
| ovf_o | output | 1 | Magnitude overflow on a same-sign sum |
| zero_o | output | 1 | Result is zero |

## Verification
The assertions run on every evaluation and check these properties:
- A negative sign never goes out with a zero magnitude.
- The zero flag tracks the output magnitude.
- Overflow appears only when the effective signs match.
- A same-sign result without overflow is never smaller than either input magnitude.
- A differing-sign result is never larger than the bigger input magnitude.
- A wrapped result is smaller than both input magnitudes.

Only the bench's scenarios can show the exact values. These include the result sign chosen after the end-around carry, the recomplement when no carry occurs, and the equivalence of subtract to add with B's sign inverted. The bench checks them against an integer model over every 8-bit operand pair for both operations.

// File: rtl/sm_pkg.sv
package sm_pkg;
  typedef enum logic {
    SM_OP_ADD = 1'b0,
    SM_OP_SUB = 1'b1
  } sm_op_e;
endpackage

// File: rtl/sm_operand_prep.sv
module sm_operand_prep #(
  parameter int W = 8
) (
  input  logic          [W-1:0] a_i,
  input  logic          [W-1:0] b_i,
  input  sm_pkg::sm_op_e        op_i,
  output logic                  sign_a_o,
  output logic                  sign_b_o,
  output logic          [W-2:0] mag_a_o,
  output logic          [W-2:0] mag_b_o,
  output logic                  same_o
);
  localparam int MW = W - 1;

  // A zero magnitude carries no sign: -0 is folded to +0 here.
  function automatic logic fold_sign(input logic s, input logic [MW-1:0] m);
    return s & (m != '0);
  endfunction

  logic raw_sign_b;

  always_comb begin
    raw_sign_b = b_i[W-1] ^ (op_i == sm_pkg::SM_OP_SUB);
    mag_a_o    = a_i[MW-1:0];
    mag_b_o    = b_i[MW-1:0];
    sign_a_o   = fold_sign(a_i[W-1], mag_a_o);
    sign_b_o   = fold_sign(raw_sign_b, mag_b_o);
    same_o     = (sign_a_o == sign_b_o);
  end
endmodule

// File: rtl/sm_mag_unit.sv
module sm_mag_unit #(
  parameter int MW = 7
) (
  input  logic [MW-1:0] mag_a_i,
  input  logic [MW-1:0] mag_b_i,
  input  logic          same_i,
  output logic [MW-1:0] mag_o,
  output logic          carry_o
);
  // Straight magnitude sum, carry in the top bit.
  function automatic logic [MW:0] plain_sum(input logic [MW-1:0] x, input logic [MW-1:0] y);
    return {1'b0, x} + {1'b0, y};
  endfunction

  // Ones'-complement difference x - y: add ~y, fold carry back, else recomplement.
  function automatic logic [MW:0] ones_diff(input logic [MW-1:0] x, input logic [MW-1:0] y);
    logic [MW:0]   t;
    logic [MW-1:0] m;
    t = {1'b0, x} + {1'b0, ~y};
    if (t[MW]) m = t[MW-1:0] + MW'(1);
    else       m = ~t[MW-1:0];
    return {t[MW], m};
  endfunction

  logic [MW:0] r;

  always_comb begin
    r       = same_i ? plain_sum(mag_a_i, mag_b_i) : ones_diff(mag_a_i, mag_b_i);
    carry_o = r[MW];
    mag_o   = r[MW-1:0];
  end
endmodule

// File: rtl/sm_result_fmt.sv
module sm_result_fmt #(
  parameter int W = 8
) (
  input  logic         sign_a_i,
  input  logic         sign_b_i,
  input  logic         same_i,
  input  logic         carry_i,
  input  logic [W-2:0] mag_i,
  output logic [W-1:0] res_o,
  output logic         ovf_o,
  output logic         zero_o
);
  logic sign_pick;
  logic mag_zero;

  always_comb begin
    mag_zero = (mag_i == '0);
    // Differing signs: a carry means A's magnitude was larger (A is never complemented).
    if (same_i) sign_pick = sign_a_i;
    else        sign_pick = carry_i ? sign_a_i : sign_b_i;
    res_o  = {sign_pick & ~mag_zero, mag_i};
    ovf_o  = same_i & carry_i;
    zero_o = mag_zero;
  end
endmodule

// File: rtl/sm_addsub.sv
module sm_addsub #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         op_i,
  output logic [W-1:0] res_o,
  output logic         ovf_o,
  output logic         zero_o
);
  localparam int MW = W - 1;

  sm_pkg::sm_op_e op_sel;
  logic           eff_sign_a;
  logic           eff_sign_b;
  logic [MW-1:0]  mag_a;
  logic [MW-1:0]  mag_b;
  logic           signs_match;
  logic           end_carry;
  logic [MW-1:0]  mag_sum;

  assign op_sel = sm_pkg::sm_op_e'(op_i);

  sm_operand_prep #(.W(W)) u_prep (
    .a_i      (a_i),
    .b_i      (b_i),
    .op_i     (op_sel),
    .sign_a_o (eff_sign_a),
    .sign_b_o (eff_sign_b),
    .mag_a_o  (mag_a),
    .mag_b_o  (mag_b),
    .same_o   (signs_match)
  );

  sm_mag_unit #(.MW(MW)) u_mag (
    .mag_a_i (mag_a),
    .mag_b_i (mag_b),
    .same_i  (signs_match),
    .mag_o   (mag_sum),
    .carry_o (end_carry)
  );

  sm_result_fmt #(.W(W)) u_fmt (
    .sign_a_i (eff_sign_a),
    .sign_b_i (eff_sign_b),
    .same_i   (signs_match),
    .carry_i  (end_carry),
    .mag_i    (mag_sum),
    .res_o    (res_o),
    .ovf_o    (ovf_o),
    .zero_o   (zero_o)
  );
endmodule

// File: rtl/sm_addsub_chk.sv
module sm_addsub_chk #(
  parameter int W = 8
) (
  input logic [W-1:0] a_i,
  input logic [W-1:0] b_i,
  input logic [W-1:0] res_o,
  input logic         ovf_o,
  input logic         zero_o,
  input logic         signs_match
);
  localparam int MW = W - 1;

  logic [MW-1:0] ma, mb, mr, mbig;

  always_comb begin
    ma   = a_i[MW-1:0];
    mb   = b_i[MW-1:0];
    mr   = res_o[MW-1:0];
    mbig = (ma > mb) ? ma : mb;

    assert_no_neg_zero_R5: assert (!(res_o[W-1] && mr == '0));
    assert_zero_flag_R6: assert (zero_o == (mr == '0));
    assert_ovf_same_sign_R8: assert (!ovf_o || signs_match);
    assert_sum_grows_R2: assert (!(signs_match && !ovf_o) || mr >= mbig);
    assert_diff_bounded_R4: assert (signs_match || mr <= mbig);
    assert_wrap_small_R3: assert (!ovf_o || (mr < ma && mr < mb));
  end
endmodule

bind sm_addsub sm_addsub_chk #(.W(W)) u_chk (
  .a_i         (a_i),
  .b_i         (b_i),
  .res_o       (res_o),
  .ovf_o       (ovf_o),
  .zero_o      (zero_o),
  .signs_match (signs_match)
);

// File: tb/sm_addsub_tb.sv
module sm_addsub_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;
  localparam int NV = 17;

  // {op, a, b, expected res, expected ovf, expected zero}
  localparam logic [26:0] VEC [NV] = '{
    {1'b0, 8'h05, 8'h03, 8'h08, 1'b0, 1'b0},  // R2
    {1'b0, 8'h85, 8'h83, 8'h88, 1'b0, 1'b0},  // R2
    {1'b0, 8'h05, 8'h83, 8'h02, 1'b0, 1'b0},  // R4
    {1'b0, 8'h03, 8'h85, 8'h82, 1'b0, 1'b0},  // R4
    {1'b0, 8'h05, 8'h85, 8'h00, 1'b0, 1'b1},  // R5 R6
    {1'b1, 8'h05, 8'h05, 8'h00, 1'b0, 1'b1},  // R1 R5
    {1'b1, 8'h05, 8'h03, 8'h02, 1'b0, 1'b0},  // R1
    {1'b1, 8'h03, 8'h05, 8'h82, 1'b0, 1'b0},  // R1 R4
    {1'b1, 8'h85, 8'h03, 8'h88, 1'b0, 1'b0},  // R1 R2
    {1'b0, 8'h64, 8'h64, 8'h48, 1'b1, 1'b0},  // R3
    {1'b0, 8'hC0, 8'hC0, 8'h00, 1'b1, 1'b1},  // R3 R5
    {1'b0, 8'h80, 8'h05, 8'h05, 1'b0, 1'b0},  // R7
    {1'b1, 8'h80, 8'h00, 8'h00, 1'b0, 1'b1},  // R7
    {1'b1, 8'h7F, 8'hFF, 8'h7E, 1'b1, 1'b0},  // R9
    {1'b0, 8'h7F, 8'hFF, 8'h00, 1'b0, 1'b1},  // R9
    {1'b1, 8'hFF, 8'h7F, 8'hFE, 1'b1, 1'b0},  // R9
    {1'b0, 8'h80, 8'h80, 8'h00, 1'b0, 1'b1}   // R7
  };

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] a, b, res;
  logic         op, ovf, zero;
  int           checks = 0;
  int           errors = 0;
  bit           done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sm_addsub #(.W(W)) u_dut (
    .a_i (a), .b_i (b), .op_i (op),
    .res_o (res), .ovf_o (ovf), .zero_o (zero)
  );

  task automatic check(input string req, input logic [9:0] act, input logic [9:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s op=%0b a=%h b=%h actual res/ovf/zero=%h expected=%h",
               req, op, a, b, act, exp);
    end
  endtask

  // Integer model: sign bit 1 = negative, magnitude in low 7 bits.
  task automatic model(input logic o, input logic [7:0] x, input logic [7:0] y,
                       output logic [9:0] e);
    int va, vb, r, m;
    logic s, v;
    va = x[7] ? -int'(x[6:0]) : int'(x[6:0]);
    vb = y[7] ? -int'(y[6:0]) : int'(y[6:0]);
    if (o) vb = -vb;
    r = va + vb;
    m = (r < 0) ? -r : r;
    v = (m > 127);
    if (v) m = m - 128;
    s = (r < 0) && (m != 0);
    e = {s, 7'(m), v, (m == 0)};
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [9:0] e;
    a = '0; b = '0; op = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check("R6 reset", {res, ovf, zero}, 10'b00000000_0_1);
    rst = 1'b0;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      op = VEC[i][26];
      a  = VEC[i][25:18];
      b  = VEC[i][17:10];
      #1;
      check("R1/R2/R3/R4/R5/R7/R9 table", {res, ovf, zero}, VEC[i][9:0]);
      #1;
    end

    // Exhaustive sweep; covers R8 (no overflow on differing signs) via the model.
    for (int o = 0; o < 2; o++) begin
      for (int x = 0; x < 256; x++) begin
        for (int y = 0; y < 256; y++) begin
          op = 1'(o); a = 8'(x); b = 8'(y);
          #1;
          model(op, a, b, e);
          check("R2/R3/R4/R8 sweep", {res, ovf, zero}, e);
          #1;
        end
      end
    end

    // R1: subtract equals add with B's sign inverted
    for (int y = 0; y < 256; y += 17) begin
      logic [9:0] sub_out;
      a = 8'h2A; b = 8'(y); op = 1'b1;
      #1; sub_out = {res, ovf, zero}; #1;
      b = 8'(y) ^ 8'h80; op = 1'b0;
      #1;
      check("R1 equivalence", {res, ovf, zero}, sub_out);
      #1;
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule